// File: doc/BRIEF.md
# Nibble-Serial Converter Word Link

This block sits between a signal-processing core and an external data converter. Both directions move 16-bit samples four bits at a time, one nibble per master-clock cycle, so one sample takes four cycles. On the receive side, nibbles arriving from the converter are gathered into whole words. Word alignment comes from a start-of-word strobe that the converter raises in the cycle that carries the first nibble. Each finished word goes to the core with a single-cycle valid pulse.

On the transmit side, the core supplies two words at each word boundary: a data sample and an echo-path sample. The block sends them out together, nibble by nibble, on two separate 4-bit buses. Transmit words are taken only at boundaries, and a transmit boundary occurs in every receive alignment cycle. If the core has nothing ready at a boundary, zero nibbles go out and a sticky flag is raised.

For test, a loopback selector feeds the transmit data stream back into the receive packer. The converter's receive nibbles are then ignored, and every accepted data word comes back to the core after a fixed delay.

Top module: `nsw_conv_if`

## Requirements
- R1: After a synchronous reset (rst_n low at a clock edge), rx_valid, rx_word, tx_nib, tx_echo_nib and tx_underflow are all zero. They stay zero, and tx_ready stays low, until the first cycle in which rx_sow is high.
- R2: Receive nibbles are taken most significant first. The nibble present in the rx_sow cycle becomes rx_word[15:12], and the nibbles of the next three cycles become bits 11:8, 7:4 and 3:0.
- R3: rx_valid is high for exactly one cycle: the cycle after the fourth nibble of a word. rx_word keeps its value while rx_valid is low.
- R4: If rx_sow comes again before four nibbles have been collected, the partial word is discarded, no rx_valid is produced for it, and assembly starts over with the nibble in the new strobe cycle.
- R5: Once aligned, the 4-cycle word phase keeps running without further strobes. A new word completes every fourth cycle.
- R6: tx_ready is high in exactly the word-boundary cycles: every cycle with rx_sow high, and every fourth cycle after it while no new strobe arrives. A transmit word pair is taken when tx_valid and tx_ready are both high.
- R7: A taken pair appears on tx_nib (data) and tx_echo_nib (echo) most significant nibble first. Bits 15:12 appear in the cycle after the boundary, followed by the lower nibbles in the next three cycles, with both buses moving together.
- R8: At a boundary where tx_valid is low, both buses send four zero nibbles and tx_underflow goes high. It stays high until reset.
- R9: With loop_en high, rx_nib is ignored. The data word taken at a boundary in cycle t is shown on rx_word with rx_valid high in cycle t+5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock from the converter side |
| rst_n | input | 1 | Synchronous active-low reset |
| loop_en | input | 1 | Selects the internal transmit-to-receive loopback |
| rx_nib | input | 4 | Receive nibble from the converter |
| rx_sow | input | 1 | Start-of-word strobe, high in the cycle of the first nibble |
| rx_word | output | 16 | Last assembled receive word |
| rx_valid | output | 1 | One-cycle pulse when rx_word is new |
| tx_data_word | input | 16 | Data sample offered by the core |
| tx_echo_word | input | 16 | Echo-path sample offered by the core |
| tx_valid | input | 1 | Core has a word pair ready |
| tx_ready | output | 1 | Word-boundary cycle; the pair is taken when tx_valid is also high |
| tx_nib | output | 4 | Transmit data nibble |
| tx_echo_nib | output | 4 | Transmit echo nibble |
| tx_underflow | output | 1 | Sticky flag for a boundary with no word ready |

## Verification
The bench uses the default build of a 16-bit word over a 4-bit bus, which gives a four-cycle word with a 2-bit phase counter. At this size every phase position, including early re-strobes at each offset, is reachable within a few hundred cycles of random strobing. The 16-bit width keeps the nibble order of R2 and R7 readable in hex. Loopback switching during random traffic also exercises the point where a half-collected word changes source.

// File: rtl/nsw_pkg.sv
package nsw_pkg;
   localparam int LANE_DATA = 0;
   localparam int LANE_ECHO = 1;
   localparam int NUM_LANES = 2;

   function automatic int unsigned ceil_log2(int unsigned n);
      int unsigned r = 0;
      while ((1 << r) < n) r++;
      return (r == 0) ? 1 : r;
   endfunction
endpackage

// File: rtl/nsw_phase.sv
module nsw_phase #(
   parameter int NIBS = 4,
   localparam int CW = nsw_pkg::ceil_log2(NIBS)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          sow,
   output logic          take,
   output logic [CW-1:0] pos
);
   logic          act_q;
   logic [CW-1:0] pos_q;

   always_comb begin
      take = sow | act_q;
      pos  = sow ? '0 : pos_q;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         act_q <= 1'b0;
         pos_q <= '0;
      end else if (take) begin
         act_q <= 1'b1;
         pos_q <= (pos == CW'(NIBS - 1)) ? '0 : pos + 1'b1;
      end
   end
endmodule

// File: rtl/nsw_rx_pack.sv
module nsw_rx_pack #(
   parameter int WORD_W = 16,
   parameter int NIB_W  = 4,
   localparam int ACC_W = WORD_W - NIB_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              take,
   input  logic              last,
   input  logic [NIB_W-1:0]  nib,
   output logic [WORD_W-1:0] word,
   output logic              valid
);
   logic [ACC_W-1:0]  acc_q;
   logic [WORD_W-1:0] full;

   assign full = {acc_q, nib};

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         acc_q <= '0;
         word  <= '0;
         valid <= 1'b0;
      end else begin
         valid <= take & last;
         if (take) begin
            acc_q <= full[ACC_W-1:0];
            if (last) word <= full;
         end
      end
   end
endmodule

// File: rtl/nsw_tx_lane.sv
module nsw_tx_lane #(
   parameter int WORD_W = 16,
   parameter int NIB_W  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic              fill,
   input  logic [WORD_W-1:0] word,
   output logic [NIB_W-1:0]  nib
);
   logic [WORD_W-1:0] sh_q;

   always_ff @(posedge clk) begin
      if (!rst_n)    sh_q <= '0;
      else if (load) sh_q <= fill ? word : '0;
      else           sh_q <= sh_q << NIB_W;
   end

   assign nib = sh_q[WORD_W-1 -: NIB_W];
endmodule

// File: rtl/nsw_conv_if.sv
module nsw_conv_if #(
   parameter int WORD_W = 16,
   parameter int NIB_W  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              loop_en,
   input  logic [NIB_W-1:0]  rx_nib,
   input  logic              rx_sow,
   output logic [WORD_W-1:0] rx_word,
   output logic              rx_valid,
   input  logic [WORD_W-1:0] tx_data_word,
   input  logic [WORD_W-1:0] tx_echo_word,
   input  logic              tx_valid,
   output logic              tx_ready,
   output logic [NIB_W-1:0]  tx_nib,
   output logic [NIB_W-1:0]  tx_echo_nib,
   output logic              tx_underflow
);
   import nsw_pkg::*;

   localparam int NIBS = WORD_W / NIB_W;
   localparam int CW   = ceil_log2(NIBS);

   if (NIB_W < 1 || WORD_W % NIB_W != 0) begin : g_bad_split
      $error("nsw_conv_if: WORD_W must be a whole multiple of NIB_W");
   end
   if (NIBS < 2) begin : g_bad_count
      $error("nsw_conv_if: a word needs at least two nibbles");
   end

   // transmit framing follows the converter strobe
   logic          tx_take;
   logic [CW-1:0] tx_pos;
   logic          tx_first;
   logic          tx_first_q;

   nsw_phase #(.NIBS(NIBS)) u_tx_phase (
      .clk  (clk),
      .rst_n(rst_n),
      .sow  (rx_sow),
      .take (tx_take),
      .pos  (tx_pos)
   );

   assign tx_first = tx_take & (tx_pos == '0);
   assign tx_ready = tx_first;

   logic [WORD_W-1:0] lane_word [NUM_LANES];
   logic [NIB_W-1:0]  lane_nib  [NUM_LANES];

   assign lane_word[LANE_DATA] = tx_data_word;
   assign lane_word[LANE_ECHO] = tx_echo_word;

   for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
      nsw_tx_lane #(.WORD_W(WORD_W), .NIB_W(NIB_W)) u_lane (
         .clk  (clk),
         .rst_n(rst_n),
         .load (tx_first),
         .fill (tx_valid),
         .word (lane_word[g]),
         .nib  (lane_nib[g])
      );
   end

   assign tx_nib      = lane_nib[LANE_DATA];
   assign tx_echo_nib = lane_nib[LANE_ECHO];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         tx_first_q   <= 1'b0;
         tx_underflow <= 1'b0;
      end else begin
         tx_first_q <= tx_first;
         if (tx_first && !tx_valid) tx_underflow <= 1'b1;
      end
   end

   // receive source selector
   logic [NIB_W-1:0] src_nib;
   logic             src_sow;

   assign src_nib = loop_en ? tx_nib     : rx_nib;
   assign src_sow = loop_en ? tx_first_q : rx_sow;

   logic          rx_take;
   logic [CW-1:0] rx_pos;

   nsw_phase #(.NIBS(NIBS)) u_rx_phase (
      .clk  (clk),
      .rst_n(rst_n),
      .sow  (src_sow),
      .take (rx_take),
      .pos  (rx_pos)
   );

   nsw_rx_pack #(.WORD_W(WORD_W), .NIB_W(NIB_W)) u_rx_pack (
      .clk  (clk),
      .rst_n(rst_n),
      .take (rx_take),
      .last (rx_pos == CW'(NIBS - 1)),
      .nib  (src_nib),
      .word (rx_word),
      .valid(rx_valid)
   );
endmodule

// File: rtl/nsw_conv_if_chk.sv
module nsw_conv_if_chk #(
   parameter int WORD_W = 16,
   parameter int NIB_W  = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              rx_sow,
   input logic [WORD_W-1:0] rx_word,
   input logic              rx_valid,
   input logic [WORD_W-1:0] tx_data_word,
   input logic [WORD_W-1:0] tx_echo_word,
   input logic              tx_valid,
   input logic              tx_ready,
   input logic [NIB_W-1:0]  tx_nib,
   input logic [NIB_W-1:0]  tx_echo_nib,
   input logic              tx_underflow
);
   AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid |=> !rx_valid); // R3
   AST_WORD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !rx_valid |-> $stable(rx_word)); // R3
   AST_READY_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
      tx_ready |=> (!tx_ready || rx_sow)); // R6
   AST_DATA_MSB_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_ready && tx_valid) |=> (tx_nib == $past(tx_data_word[WORD_W-1 -: NIB_W]))); // R7
   AST_ECHO_MSB_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_ready && tx_valid) |=> (tx_echo_nib == $past(tx_echo_word[WORD_W-1 -: NIB_W]))); // R7
   AST_UNDERFLOW_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_ready && !tx_valid) |=> (tx_nib == '0 && tx_echo_nib == '0 && tx_underflow)); // R8
   AST_UNDERFLOW_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      tx_underflow |=> tx_underflow); // R8
endmodule

bind nsw_conv_if nsw_conv_if_chk #(.WORD_W(WORD_W), .NIB_W(NIB_W)) u_chk (.*);

// File: tb/nsw_conv_if_bench.sv
module nsw_conv_if_bench;
   logic clk = 1'b0;
   always #2 clk = ~clk;

   logic        rst_n, loop_en, rx_sow, tx_valid;
   logic [3:0]  rx_nib;
   logic [15:0] tx_data_word, tx_echo_word;
   logic [15:0] rx_word;
   logic        rx_valid, tx_ready, tx_underflow;
   logic [3:0]  tx_nib, tx_echo_nib;

   nsw_conv_if u_nsw_conv_if (
      .clk(clk), .rst_n(rst_n), .loop_en(loop_en), .rx_nib(rx_nib), .rx_sow(rx_sow),
      .rx_word(rx_word), .rx_valid(rx_valid), .tx_data_word(tx_data_word),
      .tx_echo_word(tx_echo_word), .tx_valid(tx_valid), .tx_ready(tx_ready),
      .tx_nib(tx_nib), .tx_echo_nib(tx_echo_nib), .tx_underflow(tx_underflow)
   );

   int n_cmp = 0, n_bad = 0;
   bit done = 1'b0;
   bit last_ready;

   // behavioural reference state
   bit          m_ract, m_rvalid, m_tact, m_first, m_uf;
   int          m_tpos;
   int          m_rq[$], m_dq[$], m_eq[$];
   int          m_dcur, m_ecur;
   logic [15:0] m_rword;

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic model_clear();
      m_ract = 0; m_rvalid = 0; m_tact = 0; m_first = 0; m_uf = 0; m_tpos = 0;
      m_rq.delete(); m_dq.delete(); m_eq.delete();
      m_dcur = 0; m_ecur = 0; m_rword = '0;
   endtask

   function automatic bit model_boundary();
      return (rx_sow || m_tact) && ((rx_sow ? 0 : m_tpos) == 0);
   endfunction

   task automatic model_step();
      bit tb;
      int s_nib;
      bit s_sow;
      if (!rst_n) begin
         model_clear();
         return;
      end
      tb    = model_boundary();
      s_nib = loop_en ? m_dcur : int'(rx_nib);
      s_sow = loop_en ? m_first : rx_sow;
      m_rvalid = 0;
      if (s_sow) m_rq.delete();
      if (s_sow || m_ract) begin
         m_ract = 1;
         m_rq.push_back(s_nib);
         if (m_rq.size() == 4) begin
            m_rword = '0;
            foreach (m_rq[i]) m_rword = (m_rword << 4) | 16'(m_rq[i]);
            m_rvalid = 1;
            m_rq.delete();
         end
      end
      if (rx_sow || m_tact) begin
         m_tpos = ((rx_sow ? 0 : m_tpos) + 1) % 4;
         m_tact = 1;
      end
      if (tb) begin
         m_dq.delete(); m_eq.delete();
         for (int i = 0; i < 4; i++) begin
            m_dq.push_back(tx_valid ? int'((tx_data_word >> (12 - 4 * i)) & 16'hF) : 0);
            m_eq.push_back(tx_valid ? int'((tx_echo_word >> (12 - 4 * i)) & 16'hF) : 0);
         end
         if (!tx_valid) m_uf = 1;
      end
      m_dcur  = (m_dq.size() > 0) ? m_dq.pop_front() : 0;
      m_ecur  = (m_eq.size() > 0) ? m_eq.pop_front() : 0;
      m_first = tb;
   endtask

   // inputs are set at a falling edge; this compares, advances the model, waits one cycle
   task automatic tick();
      #1;
      last_ready = tx_ready;
      chk("R2 rx_word", 32'(rx_word), 32'(m_rword));
      chk("R3 rx_valid", 32'(rx_valid), 32'(m_rvalid));
      chk("R6 tx_ready", 32'(tx_ready), 32'(model_boundary()));
      chk("R7 tx_nib", 32'(tx_nib), 32'(m_dcur));
      chk("R7 tx_echo_nib", 32'(tx_echo_nib), 32'(m_ecur));
      chk("R8 tx_underflow", 32'(tx_underflow), 32'(m_uf));
      model_step();
      @(negedge clk);
   endtask

   task automatic feed(bit sow, logic [3:0] nib);
      rx_sow = sow; rx_nib = nib;
      tick();
   endtask

   initial begin
      #(4 * 20000);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      model_clear();
      rst_n = 0; loop_en = 0; rx_sow = 0; rx_nib = 4'h9; tx_valid = 1;
      tx_data_word = 16'h7E81; tx_echo_word = 16'h3C42;
      @(negedge clk);
      tick(); tick();
      rst_n = 1;
      // R1: nothing moves before the first strobe
      for (int i = 0; i < 6; i++) feed(0, 4'(i));
      chk("R1 rx_valid", 32'(rx_valid), 0);
      chk("R1 rx_word", 32'(rx_word), 0);
      chk("R1 tx_nib", 32'(tx_nib), 0);
      chk("R1 tx_echo_nib", 32'(tx_echo_nib), 0);
      chk("R1 tx_underflow", 32'(tx_underflow), 0);
      chk("R1 tx_ready", 32'(last_ready), 0);

      // R2 + R7: first aligned word both ways
      tx_data_word = 16'hB6D1; tx_echo_word = 16'h4E27;
      feed(1, 4'hA);
      chk("R6 ready on strobe", 32'(last_ready), 1);
      chk("R7 data msb", 32'(tx_nib), 32'h B);
      chk("R7 echo msb", 32'(tx_echo_nib), 32'h4);
      feed(0, 4'h5);
      chk("R7 data second", 32'(tx_nib), 32'h6);
      feed(0, 4'hC); feed(0, 4'h3);
      chk("R2 word", 32'(rx_word), 32'hA5C3);
      chk("R3 valid", 32'(rx_valid), 1);

      // R5: free-running phase, no strobe
      feed(0, 4'h1);
      chk("R3 pulse ends", 32'(rx_valid), 0);
      feed(0, 4'h2); feed(0, 4'h3); feed(0, 4'h4);
      chk("R5 word without strobe", 32'(rx_word), 32'h1234);
      chk("R5 valid without strobe", 32'(rx_valid), 1);

      // R4: early strobe drops the partial word
      feed(1, 4'h1); feed(0, 4'h2);
      feed(1, 4'hD); feed(0, 4'hE); feed(0, 4'hF);
      chk("R4 no valid for partial", 32'(rx_valid), 0);
      chk("R4 word held", 32'(rx_word), 32'h1234);
      feed(0, 4'h0);
      chk("R4 restarted word", 32'(rx_word), 32'hDEF0);
      chk("R4 restarted valid", 32'(rx_valid), 1);

      // R8: underflow
      tx_valid = 0;
      for (int i = 0; i < 8; i++) feed(0, 4'(i));
      chk("R8 zero data nibble", 32'(tx_nib), 0);
      chk("R8 flag set", 32'(tx_underflow), 1);
      tx_valid = 1;
      for (int i = 0; i < 8; i++) feed(0, 4'(i));
      chk("R8 flag sticky", 32'(tx_underflow), 1);

      // R9: loopback, converter nibbles ignored
      loop_en = 1;
      for (int i = 0; i < 8; i++) feed(0, 4'($urandom));
      tx_data_word = 16'h5A3C;
      last_ready = 0;
      for (int i = 0; i < 4 && !last_ready; i++) feed(0, 4'($urandom));
      tx_data_word = 16'h0F0F;
      for (int i = 0; i < 4; i++) feed(0, 4'($urandom));
      chk("R9 loop word", 32'(rx_word), 32'h5A3C);
      chk("R9 loop valid", 32'(rx_valid), 1);

      // mixed traffic against the model
      for (int i = 0; i < 600; i++) begin
         if ($urandom_range(0, 99) < 3) loop_en = ~loop_en;
         tx_valid     = ($urandom_range(0, 9) < 8);
         tx_data_word = 16'($urandom);
         tx_echo_word = 16'($urandom);
         feed((i % 4 == 0) || ($urandom_range(0, 99) < 4), 4'($urandom));
      end

      // R1: reset clears the sticky flag again
      rst_n = 0; rx_sow = 0;
      tick(); tick();
      rst_n = 1;
      tick();
      chk("R1 flag cleared", 32'(tx_underflow), 0);
      chk("R1 data cleared", 32'(tx_nib), 0);

      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule